// File: doc/BRIEF.md
# Round-Robin Serial Result Aggregator

This block collects per-row results from a set of functional units and stores them in a single result memory. Every unit produces four results per image row, one for each orthogonal rotation lane. The aggregator visits the units in a fixed circular order, starting at unit 0 on every row. It waits on the unit it is visiting until that unit reports a fresh result. It then pulls the four lane results one per cycle over a shared narrow read path and writes each one to memory.

Each memory address is built from four fields. The most significant field is the unit index, then the angle-step index, then the lane, and the row number is in the least significant bits. The aggregator keeps its own row and angle-step counters. When the last unit of the last row in a pass has been stored, it emits a one-cycle pulse that tells the rotation logic to start the next angle. Servicing one unit takes a fixed seven cycles, so the number of units that fit into one row period is known at design time.

A unit reports a result with a one-cycle strobe. The aggregator records the strobe as a pending flag and clears it with a one-cycle acknowledge once the four writes are done. If a unit strobes again while its previous result is still pending, the aggregator flags an overrun on that cycle.

Top module: `rr_result_aggregator`

## Requirements
- R1: While reset is held, `mem_we`, `unit_ack`, `next_angle` and `overrun` are all 0.
- R2: Units are served in ascending index order, starting at unit 0 on every row. A strobe from a higher-numbered unit produces no memory write until every lower-numbered unit has been served in that row.
- R3: One service writes four times on consecutive cycles with `mem_we` high. `rd_lane` is 0, 1, 2, 3 in turn, `rd_unit` holds the served unit, and `mem_wdata` equals `rd_data` in the same cycle.
- R4: `mem_addr` is `{unit[UNIT_W-1:0], step[STEP_W-1:0], lane[1:0], row[ROW_W-1:0]}`, with the unit in the most significant bits.
- R5: Service takes seven cycles. Count a strobe for the unit currently awaited as cycle c. Its writes then occur in cycles c+3 to c+6, and its acknowledge in cycle c+7. If the next unit is already pending, its first write follows seven cycles after the previous unit's first write.
- R6: `unit_ack` is one-hot or zero. It pulses for exactly one cycle, on the served unit's bit, in the cycle after that unit's fourth write.
- R7: A strobe from a unit whose previous result is still pending raises that unit's `overrun` bit in the same cycle. The pending result is stored only once, as a single four-write burst.
- R8: `next_angle` pulses for one cycle, one cycle after the acknowledge of the last unit on row `NUM_ROWS-1`. The step field then advances by one and wraps to 0 after `NUM_STEPS-1`.
- R9: After the last unit's acknowledge on a row, the row field advances by one, and it returns to 0 at the end of a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_new | input | NUM_UNITS | One-cycle new-result strobe per unit |
| unit_ack | output | NUM_UNITS | One-cycle acknowledge, clears the unit's result flag |
| overrun | output | NUM_UNITS | Strobe arrived while that unit's previous result was still pending |
| rd_unit | output | UNIT_W | Unit selected onto the shared read path |
| rd_lane | output | LANE_W | Lane selected onto the shared read path |
| rd_data | input | RES_W | Result returned by the selected unit and lane, same cycle |
| mem_we | output | 1 | Result memory write enable |
| mem_addr | output | UNIT_W+STEP_W+LANE_W+ROW_W | Result memory address |
| mem_wdata | output | RES_W | Result memory write data |
| next_angle | output | 1 | One-cycle request to start the next rotation angle |

## Verification
The bench strobes units out of order. A design that polled whichever unit was ready would write unit 2's lanes before unit 0 and unit 1, and its row would then finish in the wrong order. Back-to-back service checks the exact cycles of every write and acknowledge. A single wasted or missing state in the service slot shows up as shifted cycle stamps. A double strobe from one unit must flag an overrun without a second burst, so a design that queued the repeat would produce extra writes. Two full passes check that the pass-end pulse lands one cycle after the last acknowledge, and that the step field wraps to 0, where a miscounted row or step would corrupt every later address.

// File: rtl/rra_pkg.sv
package rra_pkg;

  typedef enum logic [1:0] {
    SEQ_WAIT,
    SEQ_LOAD,
    SEQ_WRITE,
    SEQ_ACK
  } seq_state_t;

endpackage

// File: rtl/agg_pending_bank.sv
module agg_pending_bank #(
  parameter int NUM_UNITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] res_new,
  input  logic [NUM_UNITS-1:0] ack,
  output logic [NUM_UNITS-1:0] pending,
  output logic [NUM_UNITS-1:0] overrun
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n)           pending[u] <= 1'b0;
      else if (res_new[u])  pending[u] <= 1'b1;
      else if (ack[u])      pending[u] <= 1'b0;
    end

    assign overrun[u] = res_new[u] & pending[u] & ~ack[u];

    // R6: an acknowledge is only ever given to a unit with a pending result
    assert_ack_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack[u] |-> pending[u]);

    // R7: an overrun keeps the single pending result alive
    assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[u] |=> pending[u]);
  end

endmodule

// File: rtl/agg_poll_seq.sv
module agg_poll_seq import rra_pkg::*; #(
  parameter int NUM_UNITS = 3,
  parameter int NUM_LANES = 4,
  parameter int UNIT_W    = 2,
  parameter int LANE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] pending,
  output logic [UNIT_W-1:0]    cur_unit,
  output logic [LANE_W-1:0]    cur_lane,
  output logic                 wr_en,
  output logic [NUM_UNITS-1:0] ack,
  output logic                 row_done
);

  localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(NUM_UNITS - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  seq_state_t state;

  function automatic logic [UNIT_W-1:0] next_unit(input logic [UNIT_W-1:0] u);
    return (u == LAST_UNIT) ? '0 : u + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_WAIT;
      cur_unit <= '0;
      cur_lane <= '0;
    end else begin
      unique case (state)
        SEQ_WAIT:  if (pending[cur_unit]) state <= SEQ_LOAD;
        SEQ_LOAD: begin
          cur_lane <= '0;
          state    <= SEQ_WRITE;
        end
        SEQ_WRITE: begin
          if (cur_lane == LAST_LANE) state <= SEQ_ACK;
          else cur_lane <= cur_lane + 1'b1;
        end
        SEQ_ACK: begin
          cur_unit <= next_unit(cur_unit);
          cur_lane <= '0;
          state    <= SEQ_WAIT;
        end
        default: state <= SEQ_WAIT;
      endcase
    end
  end

  assign wr_en    = (state == SEQ_WRITE);
  assign row_done = (state == SEQ_ACK) && (cur_unit == LAST_UNIT);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_ack
    assign ack[u] = (state == SEQ_ACK) && (cur_unit == UNIT_W'(u));
  end

  // R6: at most one unit is acknowledged at a time
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  // R6: acknowledge follows the final lane write
  assert_ack_after_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> ($past(wr_en) && $past(cur_lane) == LAST_LANE));

  // R2: writes only happen for the awaited unit while it is pending
  assert_write_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> pending[cur_unit]);

  // R3: lanes after the first follow a write on the previous cycle
  assert_lane_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cur_lane != '0) |-> ($past(wr_en) && $past(cur_lane) + 1'b1 == cur_lane));

  // R3: the served unit stays on the read path through the burst
  assert_unit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(cur_unit));

endmodule

// File: rtl/agg_pass_ctr.sv
module agg_pass_ctr #(
  parameter int ROW_W     = 8,
  parameter int NUM_ROWS  = 256,
  parameter int STEP_W    = 6,
  parameter int NUM_STEPS = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_done,
  output logic [ROW_W-1:0]  row,
  output logic [STEP_W-1:0] step,
  output logic              next_angle
);

  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic pass_end;
  assign pass_end = row_done && (row == LAST_ROW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row        <= '0;
      step       <= '0;
      next_angle <= 1'b0;
    end else begin
      next_angle <= pass_end;
      if (row_done) begin
        if (pass_end) begin
          row  <= '0;
          step <= (step == LAST_STEP) ? '0 : step + 1'b1;
        end else begin
          row <= row + 1'b1;
        end
      end
    end
  end

  // R8: the step index only moves together with the next-angle pulse
  assert_step_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step) |-> next_angle);

  // R9: a new pass always begins on row 0
  assert_pass_row_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    next_angle |-> row == '0);

endmodule

// File: rtl/rr_result_aggregator.sv
module rr_result_aggregator #(
  parameter int NUM_UNITS = 3,
  parameter int NUM_LANES = 4,
  parameter int RES_W     = 24,
  parameter int ROW_W     = 8,
  parameter int NUM_ROWS  = 256,
  parameter int STEP_W    = 6,
  parameter int NUM_STEPS = 45,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int LANE_W   = $clog2(NUM_LANES),
  localparam int ADDR_W   = UNIT_W + STEP_W + LANE_W + ROW_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] res_new,
  output logic [NUM_UNITS-1:0] unit_ack,
  output logic [NUM_UNITS-1:0] overrun,
  output logic [UNIT_W-1:0]    rd_unit,
  output logic [LANE_W-1:0]    rd_lane,
  input  logic [RES_W-1:0]     rd_data,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [RES_W-1:0]     mem_wdata,
  output logic                 next_angle
);

  logic [NUM_UNITS-1:0] pending;
  logic [UNIT_W-1:0]    cur_unit;
  logic [LANE_W-1:0]    cur_lane;
  logic                 row_done;
  logic [ROW_W-1:0]     row;
  logic [STEP_W-1:0]    step;

  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [UNIT_W-1:0] u,
    input logic [STEP_W-1:0] s,
    input logic [LANE_W-1:0] l,
    input logic [ROW_W-1:0]  r
  );
    return {u, s, l, r};
  endfunction

  agg_pending_bank #(.NUM_UNITS(NUM_UNITS)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .res_new (res_new),
    .ack     (unit_ack),
    .pending (pending),
    .overrun (overrun)
  );

  agg_poll_seq #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_LANES (NUM_LANES),
    .UNIT_W    (UNIT_W),
    .LANE_W    (LANE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (pending),
    .cur_unit (cur_unit),
    .cur_lane (cur_lane),
    .wr_en    (mem_we),
    .ack      (unit_ack),
    .row_done (row_done)
  );

  agg_pass_ctr #(
    .ROW_W     (ROW_W),
    .NUM_ROWS  (NUM_ROWS),
    .STEP_W    (STEP_W),
    .NUM_STEPS (NUM_STEPS)
  ) u_pass (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_done   (row_done),
    .row        (row),
    .step       (step),
    .next_angle (next_angle)
  );

  assign rd_unit   = cur_unit;
  assign rd_lane   = cur_lane;
  assign mem_wdata = rd_data;
  assign mem_addr  = form_addr(cur_unit, step, cur_lane, row);

  // R8: next-angle request directly follows the last unit's acknowledge
  assert_angle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    next_angle |-> $past(unit_ack[NUM_UNITS-1]));

  // R1: nothing is written or acknowledged while in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mem_we && unit_ack == '0 && !next_angle));

endmodule

// File: tb/rr_result_aggregator_test.sv
module rr_result_aggregator_test;

  localparam int NU = 3;
  localparam int ROW_SPAN = 256;
  localparam int LANE_SPAN = 4;
  localparam int STEP_SPAN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  res_new = '0;
  logic [2:0]  unit_ack, overrun;
  logic [1:0]  rd_unit, rd_lane;
  logic [23:0] rd_data;
  logic        mem_we, next_angle;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [7:0]  tag = 8'h00;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  int wr_cyc[256];
  int wr_addr[256];
  int wr_data[256];
  int wr_n = 0;
  int ack_cyc[128];
  int ack_val[128];
  int ack_n = 0;
  int ang_cyc[32];
  int ang_n = 0;

  always #2.5 clk = ~clk;

  rr_result_aggregator #(
    .NUM_UNITS(3), .NUM_LANES(4), .RES_W(24), .ROW_W(8),
    .NUM_ROWS(3), .STEP_W(2), .NUM_STEPS(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .res_new(res_new), .unit_ack(unit_ack),
    .overrun(overrun), .rd_unit(rd_unit), .rd_lane(rd_lane), .rd_data(rd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .next_angle(next_angle)
  );

  // functional-unit model: result encodes unit, lane and a per-test tag
  assign rd_data = {8'hA0 + 8'(rd_unit), 8'h50 + 8'(rd_lane), tag};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && wr_n < 256) begin
        wr_cyc[wr_n] = cyc; wr_addr[wr_n] = int'(mem_addr);
        wr_data[wr_n] = int'(mem_wdata); wr_n++;
      end
      if (unit_ack != 3'b000 && ack_n < 128) begin
        ack_cyc[ack_n] = cyc; ack_val[ack_n] = int'(unit_ack); ack_n++;
      end
      if (next_angle && ang_n < 32) begin
        ang_cyc[ang_n] = cyc; ang_n++;
      end
    end
  end

  function automatic int exp_addr(int u, int s, int l, int r);
    return ((u * STEP_SPAN + s) * LANE_SPAN + l) * ROW_SPAN + r;
  endfunction

  function automatic int exp_data(int u, int l, logic [7:0] t);
    return (160 + u) * 65536 + (80 + l) * 256 + int'(t);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] m, output int c, output logic [2:0] ov);
    @(negedge clk); #1;
    c = cyc;
    res_new = m;
    #1 ov = overrun;
    @(negedge clk); #1;
    res_new = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // checks one four-write burst starting at log index b
  task automatic check_burst(int b, int u, int s, int r, int c0, string req);
    for (int l = 0; l < 4; l++) begin
      check(req, "write cycle", wr_cyc[b + l], c0 + l);
      check("R4", "address", wr_addr[b + l], exp_addr(u, s, l, r));
      check("R3", "data", wr_data[b + l], exp_data(u, l, tag));
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", "mem_we in reset", int'(mem_we), 0);
      check("R1", "unit_ack in reset", int'(unit_ack), 0);
      check("R1", "next_angle in reset", int'(next_angle), 0);
      check("R1", "overrun in reset", int'(overrun), 0);
    end
    rst_n = 1'b1;
    idle(2);
  endtask

  // unit 0 alone: exact seven-cycle slot
  task automatic t_single();
    int c, b, a;
    logic [2:0] ov;
    tag = 8'h11; b = wr_n; a = ack_n;
    pulse(3'b001, c, ov);
    idle(10);
    check("R3", "burst length", wr_n - b, 4);
    check_burst(b, 0, 0, 0, c + 3, "R5");
    check("R6", "ack count", ack_n - a, 1);
    check("R6", "ack cycle", ack_cyc[a], c + 7);
    check("R6", "ack unit", ack_val[a], 1);
  endtask

  // unit 2 ready before unit 1: must wait its turn
  task automatic t_order();
    int c, b, a;
    logic [2:0] ov;
    tag = 8'h22; b = wr_n; a = ack_n;
    pulse(3'b100, c, ov);
    idle(12);
    check("R2", "writes while unit 1 not ready", wr_n - b, 0);
    pulse(3'b010, c, ov);
    idle(20);
    check("R2", "writes in row", wr_n - b, 8);
    check_burst(b, 1, 0, 0, c + 3, "R2");
    check_burst(b + 4, 2, 0, 0, c + 10, "R5");
    check("R6", "ack unit 1", ack_val[a], 2);
    check("R6", "ack unit 2", ack_val[a + 1], 4);
    check("R6", "ack unit 2 cycle", ack_cyc[a + 1], c + 14);
  endtask

  // all units ready together on row 1
  task automatic t_back_to_back();
    int c, b, a;
    logic [2:0] ov;
    tag = 8'h33; b = wr_n; a = ack_n;
    pulse(3'b111, c, ov);
    idle(28);
    check("R5", "writes in row", wr_n - b, 12);
    check_burst(b, 0, 0, 1, c + 3, "R9");
    check_burst(b + 4, 1, 0, 1, c + 10, "R5");
    check_burst(b + 8, 2, 0, 1, c + 17, "R5");
    check("R6", "ack cycle unit 1", ack_cyc[a + 1], c + 14);
  endtask

  // last row of a pass: next-angle pulse and step advance
  task automatic t_pass_end(int s);
    int c, b, g;
    logic [2:0] ov;
    tag = 8'h44; b = wr_n; g = ang_n;
    pulse(3'b111, c, ov);
    idle(28);
    check_burst(b + 8, 2, s, 2, c + 17, "R9");
    check("R8", "next_angle count", ang_n - g, 1);
    check("R8", "next_angle cycle", ang_cyc[g], c + 22);
  endtask

  // double strobe from unit 1 before it is served
  task automatic t_overrun();
    int c, b, a;
    logic [2:0] ov;
    tag = 8'h55; b = wr_n; a = ack_n;
    pulse(3'b010, c, ov);
    check("R7", "no overrun on first strobe", int'(ov), 0);
    pulse(3'b010, c, ov);
    check("R7", "overrun on repeat strobe", int'(ov), 2);
    idle(10);
    check("R2", "unit 1 waits for unit 0", wr_n - b, 0);
    pulse(3'b001, c, ov);
    idle(20);
    check("R7", "single burst per unit", wr_n - b, 8);
    check_burst(b, 0, 1, 0, c + 3, "R8");
    check_burst(b + 4, 1, 1, 0, c + 10, "R7");
    check("R7", "acks after overrun", ack_n - a, 2);
    pulse(3'b100, c, ov);
    idle(12);
  endtask

  task automatic run_row();
    int c;
    logic [2:0] ov;
    pulse(3'b111, c, ov);
    idle(28);
  endtask

  // second pass ends; step field wraps to 0
  task automatic t_wrap();
    int c, b;
    logic [2:0] ov;
    run_row();
    t_pass_end(1);
    tag = 8'h66; b = wr_n;
    pulse(3'b001, c, ov);
    idle(10);
    check_burst(b, 0, 0, 0, c + 3, "R8");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_order();
        t_back_to_back();
        t_pass_end(0);
        t_overrun();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule